// File: doc/BRIEF.md
# Serial Frame Detector and Byte Aligner

This block sits behind a bit-serial receive path. On every cycle where the bit-clock enable is high it takes in one received bit and places it in a sliding window of the last 48 bits. It assembles the bits into bytes, most significant bit first, and presents each byte with a one-clock strobe. The block hunts for the SONET/SDH framing run: three A1 bytes (0xF6) followed directly by three A2 bytes (0x28). When it finds that run, it moves the byte boundary so that the third A2 byte is the first byte on the new boundary. It emits that byte together with a one-clock frame pulse.

Realignment is under external control. A level-sensitive out-of-frame input (`oof`) opens the hunt. While `oof` stays high, every complete framing run realigns the boundary and pulses again. A run that completes in the cycle where `oof` is being released is still accepted. Apart from that, while `oof` is low the boundary stays frozen.

A loss-of-signal input (`los`) replaces incoming bits with zeros and forces the parallel output to zero.

The controller has two named states. In FROZEN the boundary is fixed. In HUNT the controller was told to search in the previous clock. There are two transitions: FROZEN→HUNT when `oof` is high, and HUNT→FROZEN when `oof` is low. A framing run is accepted when `oof` is high now, or when the state is HUNT. The second case covers the release cycle.

Top module: `frame_aligner`

## Requirements
- R1: While `rst_n` is low, and right after reset, `byte_out` is 0x00, `byte_vld` and `frame_pulse` are 0, the controller is FROZEN, the window is all zeros and the bit phase is 0.
- R2: Each clock with `bit_en` high samples one bit. The eighth bit since the last boundary produces `byte_vld` high for one clock on the next clock edge. `byte_out` then carries those eight bits, the earliest in bit 7.
- R3: A framing run is the last 48 sampled bits equal to F6 F6 F6 28 28 28 in order, with the earliest byte first. Runs with fewer than three A1 bytes, or fewer than three A2 bytes, are not matched.
- R4: When a run completes in a cycle where the search is allowed, the next edge gives `byte_vld`=1 and `byte_out`=0x28. The bit phase restarts, so the following byte holds exactly the next eight bits.
- R5: `frame_pulse` is high for exactly one clock. It is high together with the `byte_vld` strobe that carries the realigned third A2 byte.
- R6: The search is allowed when `oof` is high, or in the single clock in which `oof` falls after a high clock. In any other case a completed run produces no pulse and leaves the byte boundary unchanged.
- R7: While `oof` stays high, every further framing run realigns the boundary again and produces a new pulse.
- R8: Bits sampled while `los` is high enter the window as 0. Any clock with `los` high makes `byte_out` 0x00 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte-path clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Qualifies `ser_in` as one received bit this clock |
| ser_in | input | 1 | Received serial bit |
| oof | input | 1 | Level-sensitive out-of-frame: permits realignment |
| los | input | 1 | Loss of signal: zeroes incoming bits and the output byte |
| byte_out | output | 8 | Assembled byte, earliest bit in bit 7 |
| byte_vld | output | 1 | One-clock strobe for a new byte |
| frame_pulse | output | 1 | One-clock pulse with the realigned third A2 byte |

## Verification
All three outputs are registered. A byte strobe, the frame pulse and the forced-zero byte therefore appear one clock after the cycle that holds the deciding input: the eighth bit, the final pattern bit, or `los` high. The bench drives its inputs on falling edges. A reference model steps on the same rising edge using the inputs that were applied, and the bench compares at the next falling edge, when the registers have settled. Directed scenarios count pulses and check the first byte after realignment. These cover the exact release-cycle timing of `oof`, one clock early versus on time.

// File: rtl/fa_pkg.sv
package fa_pkg;
    typedef enum logic {
        ST_FROZEN = 1'b0,
        ST_HUNT   = 1'b1
    } fa_state_e;

    localparam logic [7:0] DEF_A1 = 8'hF6;
    localparam logic [7:0] DEF_A2 = 8'h28;
endpackage

// File: rtl/fa_window.sv
module fa_window #(
    parameter int WIN_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             bit_in,
    output logic [WIN_W-1:0] nxt_win
);
    logic [WIN_W-1:0] win_q;

    assign nxt_win = {win_q[WIN_W-2:0], bit_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      win_q <= '0;
        else if (bit_en) win_q <= nxt_win;
    end

    // R2
    win_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |=> (win_q[WIN_W-1:1] == $past(win_q[WIN_W-2:0])) && (win_q[0] == $past(bit_in)));
    // R2
    win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(win_q));
endmodule

// File: rtl/fa_match.sv
module fa_match #(
    parameter int         BYTE_W = 8,
    parameter int         REPS   = 3,
    parameter logic [7:0] A1     = 8'hF6,
    parameter logic [7:0] A2     = 8'h28
) (
    input  logic [2*REPS*BYTE_W-1:0] win,
    output logic                     hit
);
    localparam int NBYTES = 2 * REPS;
    logic [NBYTES-1:0] byte_ok;

    generate
        for (genvar g = 0; g < NBYTES; g++) begin : g_cmp
            // slot g counts from the newest byte; the newer half holds A2
            if (g < REPS) begin : g_a2
                assign byte_ok[g] = (win[g*BYTE_W +: BYTE_W] == BYTE_W'(A2));
            end else begin : g_a1
                assign byte_ok[g] = (win[g*BYTE_W +: BYTE_W] == BYTE_W'(A1));
            end
        end
    endgenerate

    assign hit = &byte_ok;
endmodule

// File: rtl/fa_ctrl.sv
module fa_ctrl
    import fa_pkg::*;
#(
    parameter int         BYTE_W = 8,
    parameter logic [7:0] A2     = 8'h28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              oof,
    input  logic              los,
    input  logic              pat_hit,
    input  logic [BYTE_W-1:0] nxt_byte,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_vld,
    output logic              frame_pulse
);
    localparam int PH_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(BYTE_W - 1);

    fa_state_e       state_q, state_d;
    logic [PH_W-1:0] phase_q;
    logic            search_ok, realign, byte_done;

    always_comb begin
        search_ok = oof || (state_q == ST_HUNT);
        realign   = bit_en && pat_hit && search_ok;
        byte_done = bit_en && (phase_q == PH_LAST);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FROZEN: state_d = oof ? ST_HUNT : ST_FROZEN;
            ST_HUNT:   state_d = oof ? ST_HUNT : ST_FROZEN;
            default:   state_d = ST_FROZEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FROZEN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q     <= '0;
            byte_out    <= '0;
            byte_vld    <= 1'b0;
            frame_pulse <= 1'b0;
        end else begin
            byte_vld    <= realign || byte_done;
            frame_pulse <= realign;
            if (realign || byte_done) phase_q <= '0;
            else if (bit_en)          phase_q <= phase_q + 1'b1;
            if (los)                          byte_out <= '0;
            else if (realign || byte_done)    byte_out <= nxt_byte;
        end
    end

    // R5
    fp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> !frame_pulse);
    // R5
    fp_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_pulse && !$past(los)) |-> (byte_vld && byte_out == BYTE_W'(A2)));
    // R6
    fp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |-> ($past(oof) || $past(state_q == ST_HUNT)));
    // R8
    los_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(los) |-> (byte_out == '0));
    // R4
    phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |-> (phase_q == '0));
    // R6
    frozen_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FROZEN && !oof && bit_en && phase_q != PH_LAST)
            |=> (phase_q == $past(phase_q) + 1'b1) && !frame_pulse);
endmodule

// File: rtl/frame_aligner.sv
module frame_aligner
    import fa_pkg::*;
#(
    parameter int         BYTE_W = 8,
    parameter int         REPS   = 3,
    parameter logic [7:0] A1     = DEF_A1,
    parameter logic [7:0] A2     = DEF_A2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              ser_in,
    input  logic              oof,
    input  logic              los,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_vld,
    output logic              frame_pulse
);
    localparam int WIN_W = 2 * REPS * BYTE_W;

    logic             bit_in;
    logic [WIN_W-1:0] nxt_win;
    logic             pat_hit;

    assign bit_in = ser_in & ~los;

    fa_window #(.WIN_W(WIN_W)) u_win (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in), .nxt_win(nxt_win)
    );

    fa_match #(.BYTE_W(BYTE_W), .REPS(REPS), .A1(A1), .A2(A2)) u_match (
        .win(nxt_win), .hit(pat_hit)
    );

    fa_ctrl #(.BYTE_W(BYTE_W), .A2(A2)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .oof(oof), .los(los),
        .pat_hit(pat_hit), .nxt_byte(nxt_win[BYTE_W-1:0]),
        .byte_out(byte_out), .byte_vld(byte_vld), .frame_pulse(frame_pulse)
    );

    // R1
    reset_out_chk: assert property (@(posedge clk) !rst_n |=> (byte_out == '0 && !byte_vld && !frame_pulse));
endmodule

// File: tb/frame_aligner_tb.sv
module frame_aligner_tb;
    localparam logic [47:0] PAT = 48'hF6F6F6_282828;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0, ser_in = 1'b0, oof = 1'b0, los = 1'b0;
    logic [7:0] byte_out;
    logic byte_vld, frame_pulse;

    int n_chk = 0, n_bad = 0;
    int pulses = 0;
    logic [7:0] last_byte;
    int unsigned seed_dummy;

    // reference model state
    logic [47:0] m_win;
    int          m_phase;
    logic        m_hunt;
    logic [7:0]  e_byte;
    logic        e_vld, e_fp, los_prev;

    always #5 clk = ~clk;

    frame_aligner u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_in(ser_in), .oof(oof), .los(los),
        .byte_out(byte_out), .byte_vld(byte_vld), .frame_pulse(frame_pulse)
    );

    function automatic logic [47:0] shift_in(logic [47:0] w, logic b);
        return {w[46:0], b};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_win = '0; m_phase = 0; m_hunt = 1'b0;
            e_byte = '0; e_vld = 1'b0; e_fp = 1'b0; los_prev = 1'b0;
        end else begin
            logic [47:0] nx;
            logic hit;
            nx = shift_in(m_win, ser_in & ~los);
            hit = bit_en && (nx == PAT) && (oof || m_hunt);
            e_vld = 1'b0; e_fp = 1'b0;
            if (hit) begin
                e_vld = 1'b1; e_fp = 1'b1; m_phase = 0;
                if (!los) e_byte = nx[7:0];
            end else if (bit_en) begin
                if (m_phase == 7) begin
                    e_vld = 1'b1; m_phase = 0;
                    if (!los) e_byte = nx[7:0];
                end else m_phase++;
            end
            if (los) e_byte = '0;
            if (bit_en) m_win = nx;
            m_hunt = oof;
            los_prev = los;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check("R5/R6 frame_pulse", frame_pulse, e_fp);
            check("R2 byte_vld", byte_vld, e_vld);
            check(los_prev ? "R8 byte_out" : "R2/R4 byte_out", byte_out, e_byte);
            if (frame_pulse) pulses++;
            if (byte_vld) last_byte = byte_out;
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            bit_en = 1'b0; ser_in = $urandom_range(0, 1);
            @(negedge clk);
        end
    endtask

    task automatic send_bit(logic b, logic o, int gap);
        idle(gap);
        bit_en = 1'b1; ser_in = b; oof = o;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic send_byte(logic [7:0] v, logic o);
        for (int i = 7; i >= 0; i--) send_bit(v[i], o, $urandom_range(0, 1));
    endtask

    task automatic send_rand(int n, logic o);
        for (int i = 0; i < n; i++) send_bit($urandom_range(0, 1), o, $urandom_range(0, 2));
    endtask

    task automatic send_frame(logic o);
        for (int i = 0; i < 3; i++) send_byte(8'hF6, o);
        for (int i = 0; i < 3; i++) send_byte(8'h28, o);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(1234);
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 byte_out", byte_out, 8'h00);
        check("R1 byte_vld", byte_vld, 1'b0);
        check("R1 frame_pulse", frame_pulse, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4/R5: frame recovered with oof raised well ahead, payload realigned
        send_rand(13, 1'b1);
        pulses = 0;
        send_byte(8'h00, 1'b1); send_byte(8'h00, 1'b1); send_byte(8'h00, 1'b1); send_byte(8'h00, 1'b1);
        send_frame(1'b1);
        send_byte(8'h5A, 1'b1);
        idle(2);
        check("R4 pulse count", pulses, 1);
        check("R4 byte after realign", last_byte, 8'h5A);

        // R7: two frames while oof held high, off-boundary spacing
        pulses = 0;
        send_rand(5, 1'b1); send_frame(1'b1);
        send_rand(11, 1'b1); send_frame(1'b1);
        idle(2);
        check("R7 pulse count", pulses, 2);

        // R6: oof low, misaligned frame ignored
        send_rand(3, 1'b0); idle(2);
        pulses = 0;
        send_rand(3, 1'b0); send_frame(1'b0); send_rand(16, 1'b0);
        idle(2);
        check("R6 ignored pulse count", pulses, 0);

        // R6: frame completes in the release cycle -> accepted
        send_rand(4, 1'b1);
        pulses = 0;
        for (int i = 0; i < 5; i++) send_byte(i < 3 ? 8'hF6 : 8'h28, 1'b1);
        for (int i = 7; i >= 1; i--) send_bit(PAT[i], 1'b1, 0);
        send_bit(PAT[0], 1'b0, 0);
        idle(2);
        check("R6 release-cycle pulse", pulses, 1);

        // R6: oof released one clock before final bit -> rejected
        send_rand(4, 1'b1);
        pulses = 0;
        for (int i = 0; i < 5; i++) send_byte(i < 3 ? 8'hF6 : 8'h28, 1'b1);
        for (int i = 7; i >= 1; i--) send_bit(PAT[i], 1'b1, 0);
        oof = 1'b0; idle(1);
        send_bit(PAT[0], 1'b0, 0);
        idle(2);
        check("R6 early-release pulse", pulses, 0);

        // R3: partial runs do not match
        pulses = 0;
        send_byte(8'h00, 1'b1); send_byte(8'hF6, 1'b1); send_byte(8'hF6, 1'b1);
        for (int i = 0; i < 3; i++) send_byte(8'h28, 1'b1);
        send_byte(8'h00, 1'b1);
        for (int i = 0; i < 3; i++) send_byte(8'hF6, 1'b1);
        send_byte(8'h28, 1'b1); send_byte(8'h28, 1'b1); send_byte(8'h11, 1'b1);
        idle(2);
        check("R3 partial pulse count", pulses, 0);

        // R8: loss of signal forces zero
        los = 1'b1;
        send_byte(8'hFF, 1'b1); send_byte(8'hA5, 1'b1);
        idle(1);
        check("R8 byte_out under los", byte_out, 8'h00);
        los = 1'b0;
        send_byte(8'hC3, 1'b1);
        idle(1);

        // random mix
        for (int k = 0; k < 120; k++) begin
            logic o;
            o = ($urandom_range(0, 3) != 0);
            los = ($urandom_range(0, 15) == 0);
            send_rand($urandom_range(0, 20), o);
            if ($urandom_range(0, 1) == 1) send_frame(o);
            los = 1'b0;
        end
        idle(4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule